// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block is a bus master that writes bytes to a slave with a 7-bit address over an open-drain two-wire serial bus. A processor controls it through three byte-wide registers: a data register, a control register and a status register. Software puts the slave address with a write direction bit into the data register and requests a start. The block then emits a START condition and moves the byte into an internal shift register. It shifts the byte out most significant bit first and checks the acknowledge slot after every byte. It continues with whatever byte software has left in the data register.

The data register is double buffered against the shift register. Once the first bit of a byte has been clocked out, the data register reports empty again. This gives software almost a whole byte time to supply the next byte. When the slave refuses a byte, the block raises a not-acknowledge flag and parks the bus with SCL low. Software recovers by asking for STOP together with a flush of the data register. The hardware then clears both the STOP request and the flag when the STOP condition has been sent.

The state machine has six states. IDLE leaves both lines released. START walks SDA low while SCL is high. BIT shifts one bit per SCL period. ACK releases SDA and samples the slave. HOLD keeps SCL low while it waits for software. STOP raises SDA while SCL is high.

The transitions are as follows:
- IDLE moves to START when START is requested and a byte is waiting.
- START moves to BIT and loads the shift register.
- BIT moves to ACK after the last bit.
- On an acknowledge, ACK moves to BIT when a byte is pending. Otherwise it moves to STOP when STOP is requested, and to HOLD when neither is present.
- On a refusal, ACK moves to HOLD.
- HOLD leaves for BIT when a byte arrives, but only if no refusal is flagged. It leaves for STOP when STOP is requested.
- STOP returns to IDLE.
- Clearing the enable sends every state to IDLE.

One SCL period is four quarter phases of `DIV` system clocks each. `DIV` must be at least 3.

Top module: `i2c_wr_master`

## Requirements
- R1: While the enable bit (control bit 0) is 0, the following hold:
  - the interrupt request is low;
  - after three cycles, both lines are released;
  - a START request written in the same control write has no effect;
  - START and STOP read back as 0.
- R2: The status empty flag (status bit 0) reads 1 when no byte is waiting. The interrupt request is high when the block is enabled and either of two conditions holds: transmit-interrupt enable (control bit 1) is set while the empty flag is 1, or the not-acknowledge flag is set.
- R3: Writing control bit 2 (START) while a byte is waiting produces exactly one START condition, in which SDA falls while SCL is high. START then reads back as 0.
- R4: The address byte and each following data byte appear on SDA most significant bit first. SDA changes only while SCL is low, except inside START and STOP conditions.
- R5: The empty flag stays 0 during the high phase of the first bit of a byte. It is 1 before the second SCL rising edge of that byte.
- R6: A low SDA during the high phase of the ninth SCL pulse sets the ACK status flag (status bit 1).
- R7: A high SDA in the acknowledge slot sets the not-acknowledge flag (status bit 2), clears ACK, and asserts the interrupt request.
- R8: After a not-acknowledge, a control write that sets STOP (bit 3) and FLUSH (bit 4) produces one STOP condition. After that condition, STOP and the not-acknowledge flag both read 0.
- R9: Behaviour after an acknowledged byte depends on what is waiting:
  - a waiting byte is sent next;
  - otherwise a STOP request ends the transfer;
  - with neither present, SCL is held low until one of them arrives.
- R10: FLUSH discards a waiting byte at once, so the empty flag reads 1.
- R11: Inside a byte, consecutive SCL rising edges are 4*DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 2 | Write address: 0 data, 1 control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest situation to reach from the ports is a refusal while a further byte is already buffered. The bench brings it about with a slave model that refuses a chosen byte index. The processor model preloads the next byte as soon as the empty flag returns, so a byte is pending at the moment of refusal. That pending byte must not be sent, and the flush must clear it. A second hard case is the HOLD state. A directed test withholds both data and STOP after the address is acknowledged, checks that SCL stays low, and then supplies the byte late.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] RA_DATA = 2'd0;
    localparam logic [REG_AW-1:0] RA_CTRL = 2'd1;
    localparam logic [REG_AW-1:0] RA_STAT = 2'd2;

    localparam int CB_EN    = 0;
    localparam int CB_TXIE  = 1;
    localparam int CB_START = 2;
    localparam int CB_STOP  = 3;
    localparam int CB_FLUSH = 4;

    localparam int SB_EMPTY = 0;
    localparam int SB_ACK   = 1;
    localparam int SB_NACK  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_HOLD,
        ST_STOP
    } wr_state_e;

endpackage

// File: rtl/i2c_wr_tick.sv
module i2c_wr_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs
    import i2c_wr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [REG_AW-1:0] raddr,
    output logic [DW-1:0]     rdata,
    input  logic              start_taken,
    input  logic              first_bit_out,
    input  logic              ack_set,
    input  logic              nack_set,
    input  logic              stop_done,
    output logic              en,
    output logic              txie,
    output logic              start_req,
    output logic              stop_req,
    output logic              full,
    output logic [DW-1:0]     data,
    output logic              ack,
    output logic              ncki,
    output logic              irq
);
    logic ctrl_wr;
    logic en_next;

    assign ctrl_wr = we && (waddr == RA_CTRL);
    assign en_next = ctrl_wr ? wdata[CB_EN] : en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            txie      <= 1'b0;
            start_req <= 1'b0;
            stop_req  <= 1'b0;
            full      <= 1'b0;
            data      <= '0;
            ack       <= 1'b0;
            ncki      <= 1'b0;
        end else begin
            if (start_taken) start_req <= 1'b0;
            if (stop_done) begin
                stop_req <= 1'b0;
                ncki     <= 1'b0;
            end
            if (ack_set) ack <= 1'b1;
            if (nack_set) begin
                ncki <= 1'b1;
                ack  <= 1'b0;
            end
            if (first_bit_out) full <= 1'b0;
            if (we && waddr == RA_DATA) begin
                data <= wdata;
                full <= 1'b1;
            end
            if (ctrl_wr) begin
                en   <= wdata[CB_EN];
                txie <= wdata[CB_TXIE];
                if (wdata[CB_START]) start_req <= 1'b1;
                if (wdata[CB_STOP])  stop_req  <= 1'b1;
                if (wdata[CB_FLUSH]) full      <= 1'b0;
            end
            if (!en_next) begin
                start_req <= 1'b0;
                stop_req  <= 1'b0;
                ncki      <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (raddr)
            RA_DATA: rdata = data;
            RA_CTRL: begin
                rdata[CB_EN]    = en;
                rdata[CB_TXIE]  = txie;
                rdata[CB_START] = start_req;
                rdata[CB_STOP]  = stop_req;
            end
            RA_STAT: begin
                rdata[SB_EMPTY] = !full;
                rdata[SB_ACK]   = ack;
                rdata[SB_NACK]  = ncki;
            end
            default: rdata = '0;
        endcase
    end

    assign irq = en && ((txie && !full) || ncki);

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import i2c_wr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          full,
    input  logic [DW-1:0] data,
    input  logic          ncki,
    input  logic          sda_i,
    output wr_state_e     state,
    output logic          scl_low,
    output logic          sda_low,
    output logic          start_taken,
    output logic          load,
    output logic          first_bit_out,
    output logic          ack_set,
    output logic          nack_set,
    output logic          stop_done
);
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0] TOP_BIT = BCW'(DW - 1);

    wr_state_e      state_n;
    logic [1:0]     q;
    logic [BCW-1:0] bitcnt;
    logic [DW-1:0]  shreg;
    logic           nacked;
    logic           scl_lo_c;
    logic           sda_lo_c;
    logic           sda_d1;

    // next state and event strobes
    always_comb begin
        state_n       = state;
        start_taken   = 1'b0;
        load          = 1'b0;
        first_bit_out = 1'b0;
        ack_set       = 1'b0;
        nack_set      = 1'b0;
        stop_done     = 1'b0;
        if (!en) begin
            state_n = ST_IDLE;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (start_req && full) begin
                        state_n     = ST_START;
                        start_taken = 1'b1;
                    end
                end
                ST_START: begin
                    if (q == 2'd3) begin
                        state_n = ST_BIT;
                        load    = 1'b1;
                    end
                end
                ST_BIT: begin
                    if (q == 2'd3) begin
                        if (bitcnt == TOP_BIT) first_bit_out = 1'b1;
                        if (bitcnt == '0)      state_n = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (q == 2'd2) begin
                        if (sda_i) nack_set = 1'b1;
                        else       ack_set  = 1'b1;
                    end else if (q == 2'd3) begin
                        if (nacked) begin
                            state_n = ST_HOLD;
                        end else if (full) begin
                            state_n = ST_BIT;
                            load    = 1'b1;
                        end else if (stop_req) begin
                            state_n = ST_STOP;
                        end else begin
                            state_n = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (ncki) begin
                        if (stop_req) state_n = ST_STOP;
                    end else if (full) begin
                        state_n = ST_BIT;
                        load    = 1'b1;
                    end else if (stop_req) begin
                        state_n = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (q == 2'd3) begin
                        state_n   = ST_IDLE;
                        stop_done = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            q     <= 2'd0;
        end else begin
            state <= state_n;
            if (state_n != state) begin
                q <= 2'd0;
            end else if (tick && state != ST_IDLE && state != ST_HOLD) begin
                q <= q + 2'd1;
            end
        end
    end

    // shift path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            nacked <= 1'b0;
        end else begin
            if (load) begin
                shreg  <= data;
                bitcnt <= TOP_BIT;
            end else if (tick && state == ST_BIT && q == 2'd3) begin
                shreg  <= {shreg[DW-2:0], 1'b0};
                bitcnt <= bitcnt - 1'b1;
            end
            if (nack_set)     nacked <= 1'b1;
            else if (ack_set) nacked <= 1'b0;
        end
    end

    // line levels per state and quarter
    always_comb begin
        scl_lo_c = 1'b0;
        sda_lo_c = 1'b0;
        unique case (state)
            ST_IDLE: begin
                scl_lo_c = 1'b0;
                sda_lo_c = 1'b0;
            end
            ST_START: begin
                scl_lo_c = (q == 2'd3);
                sda_lo_c = (q >= 2'd2);
            end
            ST_BIT: begin
                scl_lo_c = (q < 2'd2);
                sda_lo_c = !shreg[DW-1];
            end
            ST_ACK: begin
                scl_lo_c = (q < 2'd2);
                sda_lo_c = 1'b0;
            end
            ST_HOLD: begin
                scl_lo_c = 1'b1;
                sda_lo_c = 1'b1;
            end
            ST_STOP: begin
                scl_lo_c = (q == 2'd0);
                sda_lo_c = (q < 2'd2);
            end
            default: begin
                scl_lo_c = 1'b0;
                sda_lo_c = 1'b0;
            end
        endcase
    end

    // SDA lags SCL by one extra clock so it never moves on an SCL edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_low <= 1'b0;
            sda_d1  <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            scl_low <= scl_lo_c;
            sda_d1  <= sda_lo_c;
            sda_low <= sda_d1;
        end
    end

endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
    import i2c_wr_pkg::*;
#(
    parameter int DIV = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_waddr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [REG_AW-1:0] bus_raddr,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o
);
    logic          en;
    logic          txie;
    logic          start_req;
    logic          stop_req;
    logic          full;
    logic [DW-1:0] data;
    logic          ack;
    logic          ncki;
    logic          tick;
    logic          start_taken;
    logic          load;
    logic          first_bit_out;
    logic          ack_set;
    logic          nack_set;
    logic          stop_done;
    wr_state_e     state;

    i2c_wr_regs #(.DW(DW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (bus_we),
        .waddr        (bus_waddr),
        .wdata        (bus_wdata),
        .raddr        (bus_raddr),
        .rdata        (bus_rdata),
        .start_taken  (start_taken),
        .first_bit_out(first_bit_out),
        .ack_set      (ack_set),
        .nack_set     (nack_set),
        .stop_done    (stop_done),
        .en           (en),
        .txie         (txie),
        .start_req    (start_req),
        .stop_req     (stop_req),
        .full         (full),
        .data         (data),
        .ack          (ack),
        .ncki         (ncki),
        .irq          (irq)
    );

    i2c_wr_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en),
        .tick (tick)
    );

    i2c_wr_fsm #(.DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .tick         (tick),
        .start_req    (start_req),
        .stop_req     (stop_req),
        .full         (full),
        .data         (data),
        .ncki         (ncki),
        .sda_i        (sda_i),
        .state        (state),
        .scl_low      (scl_low_o),
        .sda_low      (sda_low_o),
        .start_taken  (start_taken),
        .load         (load),
        .first_bit_out(first_bit_out),
        .ack_set      (ack_set),
        .nack_set     (nack_set),
        .stop_done    (stop_done)
    );

endmodule

// File: rtl/i2c_wr_master_chk.sv
module i2c_wr_master_chk
    import i2c_wr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      en,
    input logic      irq,
    input logic      ack,
    input logic      ncki,
    input logic      scl_low,
    input logic      sda_low,
    input wr_state_e state,
    input logic      stop_req,
    input logic      full,
    input logic      load
);
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en) && !$past(en, 2) && !$past(en, 3)) |-> (!irq && !scl_low && !sda_low)); // R1

    AST_NACK_EXCLUDES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ncki |-> !ack); // R7

    AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> full); // R9

    AST_STOP_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_STOP && state == ST_IDLE) |-> (!stop_req && !ncki)); // R8

    AST_SDA_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(en, 2) && !scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
        |-> (state == ST_START || state == ST_STOP)); // R4

endmodule

bind i2c_wr_master i2c_wr_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .irq     (irq),
    .ack     (ack),
    .ncki    (ncki),
    .scl_low (scl_low_o),
    .sda_low (sda_low_o),
    .state   (state),
    .stop_req(stop_req),
    .full    (full),
    .load    (load)
);

// File: tb/i2c_wr_master_tb.sv
module i2c_wr_master_tb;
    localparam int DIV = 4;
    localparam logic [7:0] K_EN = 8'h01, K_TXIE = 8'h02, K_START = 8'h04, K_STOP = 8'h08, K_FLUSH = 8'h10;
    localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;
    localparam int NV = 5;
    // {addr7, nbytes, d0, d1, nack (0 none, 1 address, 2 first data), pad}
    localparam logic [27:0] VEC [0:NV-1] = '{
        {7'h50, 2'd2, 8'hA5, 8'h3C, 2'd0, 1'b0},
        {7'h2B, 2'd1, 8'h81, 8'h00, 2'd0, 1'b0},
        {7'h7F, 2'd2, 8'h00, 8'hFF, 2'd0, 1'b0},
        {7'h11, 2'd2, 8'h5A, 8'h77, 2'd1, 1'b0},
        {7'h66, 2'd2, 8'hC3, 8'h99, 2'd2, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [1:0] bus_waddr = '0;
    logic [7:0] bus_wdata = '0;
    logic [1:0] bus_raddr = '0;
    logic [7:0] bus_rdata;
    logic irq;
    logic scl_low_o, sda_low_o;
    logic slv_drv = 1'b0;
    logic scl, sda;

    int total = 0;
    int bad = 0;
    longint cyc = 0;

    assign scl = !scl_low_o;
    assign sda = !(sda_low_o || slv_drv);

    always #2.5 clk = !clk;

    i2c_wr_master #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .irq(irq), .sda_i(sda), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
    );

    // slave model
    int starts = 0, stops = 0, rises = 0, bitc = 0, nrx = 0, nack_byte = -1;
    bit act = 0, armed = 0;
    logic [7:0] sh = '0;
    logic [7:0] rx [0:3];
    longint rise_cyc [0:15];

    always @(negedge sda) if (scl === 1'b1) begin
        starts++; act = 1; armed = 1; bitc = 0; rises = 0; nrx = 0; slv_drv = 0;
    end
    always @(posedge sda) if (scl === 1'b1) begin
        stops++; act = 0;
    end
    always @(posedge scl) if (act) begin
        if (rises < 16) rise_cyc[rises] = cyc;
        rises++;
        if (bitc < 8) sh = {sh[6:0], sda};
    end
    always @(negedge scl) if (act) begin
        if (armed) armed = 0;
        else begin
            bitc++;
            if (bitc == 8) begin
                if (nrx < 4) rx[nrx] = sh;
                slv_drv = (nrx != nack_byte);
                nrx++;
            end else if (bitc == 9) begin
                slv_drv = 0;
                bitc = 0;
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act_v, input int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        bus_raddr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_stops(input int target, input string req);
        for (int g = 0; g < 20000 && stops < target; g++) @(negedge clk);
        chk(req, stops >= target, 1);
        repeat (10) @(negedge clk);
    endtask

    logic [7:0] s;
    logic [7:0] c;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        starts = 0; stops = 0;

        // reset state
        bus_rd(A_STAT, s); chk("R2 reset status", s, 8'h01);
        bus_rd(A_CTRL, c); chk("R1 reset control", c, 8'h00);
        chk("R1 reset irq", irq, 0);
        chk("R4 reset lines", {scl, sda}, 2'b11);

        // R2 interrupt from empty flag
        bus_wr(A_CTRL, K_EN);
        chk("R2 irq without txie", irq, 0);
        bus_wr(A_CTRL, K_EN | K_TXIE);
        chk("R2 irq on empty", irq, 1);
        bus_wr(A_DATA, 8'h12);
        bus_rd(A_STAT, s); chk("R2 empty after write", s[0], 0);
        chk("R2 irq low when full", irq, 0);
        bus_wr(A_CTRL, K_EN | K_TXIE | K_FLUSH);
        bus_rd(A_STAT, s); chk("R10 flush empties", s[0], 1);
        chk("R2 irq after flush", irq, 1);

        // R1 disabled block ignores START
        bus_wr(A_CTRL, 8'h00);
        bus_wr(A_DATA, 8'hA0);
        bus_wr(A_CTRL, K_TXIE | K_START);
        repeat (200) @(negedge clk);
        chk("R1 no start while disabled", starts, 0);
        chk("R1 irq low while disabled", irq, 0);
        chk("R1 scl released", scl, 1);
        bus_rd(A_CTRL, c); chk("R1 start reads 0", c[2], 0);
        bus_wr(A_CTRL, K_EN | K_FLUSH);

        // R5 / R9 directed: early empty flag, then hold with SCL low
        nack_byte = -1;
        bus_wr(A_DATA, 8'hA0);
        bus_wr(A_CTRL, K_EN | K_START);
        for (int g = 0; g < 5000 && !(starts >= 1 && rises >= 1); g++) @(negedge clk);
        bus_rd(A_STAT, s); chk("R5 empty stays 0 in first bit high", s[0], 0);
        for (int g = 0; g < 5000 && rises < 2; g++) @(negedge clk);
        bus_rd(A_STAT, s); chk("R5 empty set before second rise", s[0], 1);
        repeat (400) @(negedge clk);
        chk("R9 hold keeps scl low", scl, 0);
        chk("R4 address byte", rx[0], 8'hA0);
        bus_rd(A_STAT, s); chk("R6 ack flag", s[1], 1);
        bus_wr(A_DATA, 8'h3C);
        s = 8'h00;
        for (int g = 0; g < 5000 && !s[0]; g++) begin @(negedge clk); bus_rd(A_STAT, s); end
        bus_wr(A_CTRL, K_EN | K_STOP);
        wait_stops(1, "R9 stop after held transfer");
        chk("R9 late byte sent", rx[1], 8'h3C);
        chk("R9 byte count", nrx, 2);

        // table-driven transactions
        for (int i = 0; i < NV; i++) begin
            logic [6:0] a;
            logic [1:0] n, nk;
            logic [7:0] d0, d1;
            int sent, st0, sn0, exp_n;
            bit done, sawn;
            a = VEC[i][27:21]; n = VEC[i][20:19]; d0 = VEC[i][18:11];
            d1 = VEC[i][10:3]; nk = VEC[i][2:1];
            nack_byte = (nk == 0) ? -1 : int'(nk) - 1;
            st0 = stops; sn0 = starts; sent = 0; done = 0; sawn = 0;
            bus_wr(A_DATA, {a, 1'b0});
            bus_wr(A_CTRL, K_EN | K_TXIE | K_START);
            for (int g = 0; g < 20000 && !done; g++) begin
                @(negedge clk);
                if (irq) begin
                    bus_rd(A_STAT, s);
                    if (s[2]) begin
                        chk("R7 ack cleared on nack", s[1], 0);
                        sawn = 1;
                        bus_wr(A_CTRL, K_EN | K_STOP | K_FLUSH);
                        bus_rd(A_STAT, s); chk("R10 flush drops pending byte", s[0], 1);
                        done = 1;
                    end else if (s[0]) begin
                        if (sent < int'(n)) begin
                            bus_wr(A_DATA, (sent == 0) ? d0 : d1);
                            sent++;
                        end else begin
                            bus_wr(A_CTRL, K_EN | K_STOP);
                            done = 1;
                        end
                    end
                end
            end
            wait_stops(st0 + 1, "R8 stop condition");
            chk("R3 one start", starts - sn0, 1);
            chk("R8 one stop", stops - st0, 1);
            exp_n = (nk == 0) ? 1 + int'(n) : int'(nk);
            chk("R9 bytes on bus", nrx, exp_n);
            chk("R4 address msb first", rx[0], {a, 1'b0});
            chk("R11 scl period", int'(rise_cyc[2] - rise_cyc[1]), 4 * DIV);
            bus_rd(A_CTRL, c);
            chk("R3 start cleared", c[2], 0);
            chk("R8 stop cleared", c[3], 0);
            bus_rd(A_STAT, s);
            chk("R8 nack cleared", s[2], 0);
            if (nk == 0) begin
                chk("R6 ack after transfer", s[1], 1);
                chk("R4 data0", rx[1], d0);
                if (n == 2) chk("R4 data1", rx[2], d1);
            end else begin
                chk("R7 nack raised irq", sawn, 1);
                chk("R7 ack low after nack", s[1], 0);
            end
        end

        finish_run();
    end

endmodule